// File: doc/BRIEF.md
# Flash Write-Protection Status Controller

This block keeps the eight-bit status register of a serial flash device and rules on every write-type command before it reaches the array sequencer. A front-end decoder hands it one command event per clock: the operation, the target address, the byte written by a status update, and a flag that says whether chip select rose on a whole byte. The block answers with a one-cycle accept or reject pulse on the next clock. It updates the write-enable latch and the protection configuration, and it raises BUSY for the length of the self-timed program, erase or status-write cycle.

An internal countdown stands in for the array's cycle timer. When the countdown expires, BUSY and the write-enable latch drop on the same clock edge. Block protection covers a power-of-two number of 64 KB blocks at the top or the bottom of the array. Program, sector erase and block erase check that protection against the target address. Chip erase is refused whenever any block is protected.

Top module: `flash_wp_ctrl`

## Requirements
- R1: After reset, status_byte is 8'h00 and neither cmd_accept nor cmd_reject is high. The status layout is: bit 0 BUSY, bit 1 write-enable latch, bits 4:2 protect level, bit 5 bottom-select, bit 6 always 0, bit 7 status-lock.
- R2: cmd_op encodes 0 write-enable, 1 write-disable, 2 write-status, 3 program, 4 sector erase, 5 block erase, 6 chip erase; code 7 is always rejected. On the clock after a cycle with cmd_valid high, exactly one of cmd_accept or cmd_reject is high for one cycle. With no command, both stay low. Any state change shows on status_byte in that same cycle.
- R3: An accepted write-enable sets the write-enable latch. An accepted write-disable clears it.
- R4: Codes 2 to 6 are rejected while the write-enable latch is 0. A rejected command changes no status bit.
- R5: An accepted write-status loads bit 7, bit 5 and bits 4:2 of cmd_wdata into the status-lock, bottom-select and protect-level fields. Data bits 0, 1 and 6 have no effect.
- R6: With status-lock 1 and wp_n low, write-status is rejected. With status-lock 0, or with wp_n high, the level of wp_n has no effect.
- R7: Any command with cmd_byte_aligned low is rejected and changes no state.
- R8: An accepted code 2 to 6 holds BUSY at 1 for exactly BUSY_CYCLES clock cycles. BUSY and the write-enable latch then clear on the same edge.
- R9: While BUSY is 1, every command is rejected and changes no state.
- R10: With the default 20-bit address, block index = cmd_addr[19:16]. Protect level 0 protects nothing. Levels 1 to 4 protect 1, 2, 4 or 8 blocks: the highest blocks when bottom-select is 0, the lowest when it is 1. Levels 5 to 7 protect all blocks. Program and sector or block erase to a protected block are rejected.
- R11: Chip erase is rejected whenever the protect level is not 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A decoded command is present this cycle |
| cmd_op | input | 3 | Operation code (see R2) |
| cmd_addr | input | ADDR_W | Target byte address |
| cmd_byte_aligned | input | 1 | Chip select rose on a whole byte |
| cmd_wdata | input | 8 | Data byte for write-status |
| wp_n | input | 1 | Write-protect pin, active low |
| cmd_accept | output | 1 | Command accepted (one cycle) |
| cmd_reject | output | 1 | Command rejected (one cycle) |
| busy | output | 1 | Self-timed cycle in progress |
| wel | output | 1 | Write-enable latch |
| status_byte | output | 8 | Status register for readout |

## Verification
The hardest corners combine a locked status register with the pin low, or place an address exactly on the edge of a protected range after a fresh configuration write. The stimulus reaches them in stages. It writes a configuration, waits out BUSY, then re-arms the latch before each probe. It sweeps every protect level against both halves and against all sixteen blocks, with a chip erase per setting. A behavioural model advances every clock and compares all outputs, so a command that lands while BUSY is high is also caught.

// File: rtl/flash_wp_pkg.sv
package flash_wp_pkg;

    typedef enum logic [2:0] {
        OP_WEN    = 3'd0,
        OP_WDIS   = 3'd1,
        OP_WSTAT  = 3'd2,
        OP_PROG   = 3'd3,
        OP_SERASE = 3'd4,
        OP_BERASE = 3'd5,
        OP_CERASE = 3'd6,
        OP_NONE   = 3'd7
    } wp_op_e;

    typedef struct packed {
        logic       lock;
        logic       bottom;
        logic [2:0] level;
        logic       wel;
        logic       acc;
        logic       rej;
    } wp_regs_t;

endpackage

// File: rtl/wp_range_decode.sv
module wp_range_decode #(
    parameter int ADDR_W    = 20,
    parameter int BLK_SHIFT = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-BLK_SHIFT-1:0] blk_idx,
    input  logic [2:0]                  level,
    input  logic                        bottom,
    output logic                        addr_hit,
    output logic                        any_prot
);
    localparam int BLK_W = ADDR_W - BLK_SHIFT;
    localparam int NBLK  = 1 << BLK_W;

    logic [31:0]     span;
    logic [NBLK-1:0] blk_prot;

    always_comb begin
        if (level == 3'd0) span = 32'd0;
        else               span = 32'd1 << (level - 3'd1);
    end

    for (genvar i = 0; i < NBLK; i++) begin : g_blk
        assign blk_prot[i] = (span != 32'd0) &&
                             ((span >= 32'(NBLK)) ||
                              (bottom ? (32'(i) < span) : (32'(i) >= 32'(NBLK) - span)));
    end

    assign addr_hit = blk_prot[blk_idx];
    assign any_prot = |blk_prot;

    // R10
    no_level_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level == 3'd0) |-> (!addr_hit && !any_prot));
    // R11
    some_level_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level != 3'd0) |-> any_prot);

endmodule

// File: rtl/wp_op_timer.sv
module wp_op_timer #(
    parameter int BUSY_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy_o,
    output logic done_o
);
    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)                   cnt_d = CNT_W'(BUSY_CYCLES);
        else if (cnt_q != '0)        cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);
    assign done_o = (cnt_q == CNT_W'(1));

    // R8
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy_o);
    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);
    // R9
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !start);

endmodule

// File: rtl/wp_permit.sv
module wp_permit
    import flash_wp_pkg::*;
(
    input  wp_op_e op,
    input  logic   aligned,
    input  logic   busy,
    input  logic   wel,
    input  logic   lock,
    input  logic   wp_n,
    input  logic   addr_hit,
    input  logic   any_prot,
    output logic   permit,
    output logic   timed
);
    logic gate;

    always_comb begin
        gate   = aligned && !busy;
        permit = 1'b0;
        timed  = 1'b0;
        unique case (op)
            OP_WEN, OP_WDIS: permit = gate;
            OP_WSTAT: begin
                permit = gate && wel && !(lock && !wp_n);
                timed  = 1'b1;
            end
            OP_PROG, OP_SERASE, OP_BERASE: begin
                permit = gate && wel && !addr_hit;
                timed  = 1'b1;
            end
            OP_CERASE: begin
                permit = gate && wel && !any_prot;
                timed  = 1'b1;
            end
            default: permit = 1'b0;
        endcase
    end

endmodule

// File: rtl/flash_wp_ctrl.sv
module flash_wp_ctrl
    import flash_wp_pkg::*;
#(
    parameter int ADDR_W      = 20,
    parameter int BLK_SHIFT   = 16,
    parameter int BUSY_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              cmd_byte_aligned,
    input  logic [7:0]        cmd_wdata,
    input  logic              wp_n,
    output logic              cmd_accept,
    output logic              cmd_reject,
    output logic              busy,
    output logic              wel,
    output logic [7:0]        status_byte
);
    wp_regs_t regs_d, regs_q;
    wp_op_e   op;
    logic     addr_hit, any_prot, permit, timed, done, start;
    logic     unused_bits;

    assign op          = wp_op_e'(cmd_op);
    assign unused_bits = ^{cmd_addr[BLK_SHIFT-1:0], cmd_wdata[6], cmd_wdata[1:0]};

    wp_range_decode #(.ADDR_W(ADDR_W), .BLK_SHIFT(BLK_SHIFT)) u_range (
        .clk      (clk),
        .rst_n    (rst_n),
        .blk_idx  (cmd_addr[ADDR_W-1:BLK_SHIFT]),
        .level    (regs_q.level),
        .bottom   (regs_q.bottom),
        .addr_hit (addr_hit),
        .any_prot (any_prot)
    );

    wp_permit u_permit (
        .op       (op),
        .aligned  (cmd_byte_aligned),
        .busy     (busy),
        .wel      (regs_q.wel),
        .lock     (regs_q.lock),
        .wp_n     (wp_n),
        .addr_hit (addr_hit),
        .any_prot (any_prot),
        .permit   (permit),
        .timed    (timed)
    );

    assign start = cmd_valid && permit && timed;

    wp_op_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .busy_o (busy),
        .done_o (done)
    );

    always_comb begin
        regs_d     = regs_q;
        regs_d.acc = 1'b0;
        regs_d.rej = 1'b0;
        if (done) regs_d.wel = 1'b0;
        if (cmd_valid) begin
            if (permit) begin
                regs_d.acc = 1'b1;
                case (op)
                    OP_WEN:  regs_d.wel = 1'b1;
                    OP_WDIS: regs_d.wel = 1'b0;
                    OP_WSTAT: begin
                        regs_d.lock   = cmd_wdata[7];
                        regs_d.bottom = cmd_wdata[5];
                        regs_d.level  = cmd_wdata[4:2];
                    end
                    default: ;
                endcase
            end else begin
                regs_d.rej = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign cmd_accept  = regs_q.acc;
    assign cmd_reject  = regs_q.rej;
    assign wel         = regs_q.wel;
    assign status_byte = {regs_q.lock, 1'b0, regs_q.bottom, regs_q.level, regs_q.wel, busy};

    // R2
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> (cmd_accept != cmd_reject));
    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> (!cmd_accept && !cmd_reject));
    // R4
    wel_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op >= 3'd2 && !wel) |=> cmd_reject);
    // R6
    lock_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd2 && status_byte[7] && !wp_n) |=> cmd_reject);
    // R7
    partial_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_byte_aligned) |=> cmd_reject);
    // R9
    busy_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && busy) |=> cmd_reject);
    // R8
    wel_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !wel);
    // R5
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> $stable(status_byte[7:2]));

endmodule

// File: tb/sim_flash_wp_ctrl.sv
`timescale 1ns/1ps
module sim_flash_wp_ctrl;
    localparam int BUSY_CYCLES = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic [19:0] cmd_addr = '0;
    logic        cmd_byte_aligned = 1'b1;
    logic [7:0]  cmd_wdata = 8'h00;
    logic        wp_n = 1'b1;
    logic        cmd_accept, cmd_reject, busy, wel;
    logic [7:0]  status_byte;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit checking = 1'b0;
    string cur_req = "R1";
    logic last_acc, last_rej;

    // behavioural reference model
    int m_wel, m_lock, m_bot, m_lvl, m_bcnt, m_acc, m_rej;

    always #2.5 clk = ~clk;

    flash_wp_ctrl #(.BUSY_CYCLES(BUSY_CYCLES)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_byte_aligned(cmd_byte_aligned),
        .cmd_wdata(cmd_wdata), .wp_n(wp_n), .cmd_accept(cmd_accept),
        .cmd_reject(cmd_reject), .busy(busy), .wel(wel), .status_byte(status_byte)
    );

    function automatic bit in_guarded(int addr, int lvl, int bot);
        int bytes;
        if (lvl == 0) return 1'b0;
        if (lvl >= 5) return 1'b1;
        bytes = (1 << (lvl - 1)) * 65536;
        if (bot != 0) return addr < bytes;
        return addr >= (1048576 - bytes);
    endfunction

    function automatic int exp_status();
        return (m_lock << 7) | (m_bot << 5) | (m_lvl << 2) | (m_wel << 1) | (m_bcnt != 0 ? 1 : 0);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_wel = 0; m_lock = 0; m_bot = 0; m_lvl = 0; m_bcnt = 0; m_acc = 0; m_rej = 0;
        end else begin
            automatic bit was_busy = (m_bcnt != 0);
            automatic bit ok = 1'b0;
            automatic int op = int'(cmd_op);
            m_acc = 0; m_rej = 0;
            if (m_bcnt > 0) begin
                if (m_bcnt == 1) m_wel = 0;
                m_bcnt--;
            end
            if (cmd_valid) begin
                if (cmd_byte_aligned && !was_busy) begin
                    if (op == 0 || op == 1) ok = 1'b1;
                    else if (op == 2) ok = (m_wel == 1) && !(m_lock == 1 && !wp_n);
                    else if (op >= 3 && op <= 5) ok = (m_wel == 1) && !in_guarded(int'(cmd_addr), m_lvl, m_bot);
                    else if (op == 6) ok = (m_wel == 1) && (m_lvl == 0);
                end
                if (ok) begin
                    m_acc = 1;
                    if (op == 0) m_wel = 1;
                    else if (op == 1) m_wel = 0;
                    else begin
                        if (op == 2) begin
                            m_lock = cmd_wdata[7]; m_bot = cmd_wdata[5]; m_lvl = int'(cmd_wdata[4:2]);
                        end
                        m_bcnt = BUSY_CYCLES;
                    end
                end else m_rej = 1;
            end
        end
    end

    always @(negedge clk) begin
        if (checking) begin
            n_tests++;
            if (status_byte !== 8'(exp_status()) || cmd_accept !== m_acc[0] || cmd_reject !== m_rej[0]) begin
                n_fail++;
                $display("FAIL %s cycle %0d: status/acc/rej actual %02h/%0b/%0b expected %02h/%0d/%0d",
                         cur_req, cyc, status_byte, cmd_accept, cmd_reject, exp_status(), m_acc, m_rej);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog R8: run hung, actual cycle %0d expected completion", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit cond, input string req, input int act, input int exp);
        n_tests++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic issue(input int op, input int addr, input bit al, input int data);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op[2:0]; cmd_addr = addr[19:0];
        cmd_byte_aligned = al; cmd_wdata = data[7:0];
        @(negedge clk);
        cmd_valid = 1'b0;
        last_acc = cmd_accept; last_rej = cmd_reject;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic set_cfg(input int data);
        issue(0, 0, 1'b1, 0);
        issue(2, 0, 1'b1, data);
        wait_idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checking = 1'b1;
        cur_req = "R1";
        chk(status_byte == 8'h00 && !cmd_accept && !cmd_reject, "R1 reset", status_byte, 0);

        cur_req = "R4";
        issue(3, 0, 1'b1, 0);
        chk(last_rej && status_byte == 8'h00, "R4 program without latch", status_byte, 0);

        cur_req = "R3";
        issue(0, 0, 1'b1, 0);
        chk(last_acc && status_byte == 8'h02, "R3 enable", status_byte, 8'h02);
        issue(1, 0, 1'b1, 0);
        chk(last_acc && status_byte == 8'h00, "R3 disable", status_byte, 0);

        cur_req = "R2";
        issue(7, 0, 1'b1, 0);
        chk(last_rej && !last_acc, "R2 unused code", last_acc, 0);

        cur_req = "R7";
        issue(0, 0, 1'b1, 0);
        issue(3, 0, 1'b0, 0);
        chk(last_rej && status_byte == 8'h02, "R7 partial program", status_byte, 8'h02);
        issue(1, 0, 1'b0, 0);
        chk(last_rej && status_byte == 8'h02, "R7 partial disable", status_byte, 8'h02);

        cur_req = "R8";
        begin
            int n;
            issue(3, 32'h00400, 1'b1, 0);
            n = 0;
            while (busy) begin n++; @(negedge clk); end
            chk(n == BUSY_CYCLES, "R8 busy length", n, BUSY_CYCLES);
            chk(status_byte == 8'h00, "R8 latch cleared", status_byte, 0);
        end

        cur_req = "R9";
        issue(0, 0, 1'b1, 0);
        issue(4, 32'h10000, 1'b1, 0);
        issue(1, 0, 1'b1, 0);
        chk(last_rej && status_byte == 8'h03, "R9 disable during busy", status_byte, 8'h03);
        issue(0, 0, 1'b1, 0);
        chk(last_rej, "R9 enable during busy", last_acc, 0);
        wait_idle();

        cur_req = "R5";
        set_cfg(8'h43);
        chk(status_byte == 8'h00, "R5 ignored data bits", status_byte, 0);
        set_cfg(8'hFF);
        chk(status_byte == 8'hBC, "R5 all writable", status_byte, 8'hBC);

        cur_req = "R6";
        wp_n = 1'b0;
        issue(0, 0, 1'b1, 0);
        issue(2, 0, 1'b1, 8'h00);
        chk(last_rej && status_byte == 8'hBE, "R6 locked by pin", status_byte, 8'hBE);
        wp_n = 1'b1;
        issue(2, 0, 1'b1, 8'h00);
        wait_idle();
        chk(last_acc && status_byte == 8'h00, "R6 pin high unlocks", status_byte, 0);
        wp_n = 1'b0;
        set_cfg(8'h04);
        chk(status_byte == 8'h04, "R6 unlocked ignores pin", status_byte, 8'h04);
        wp_n = 1'b1;

        for (int lvl = 0; lvl < 8; lvl++) begin
            for (int bot = 0; bot < 2; bot++) begin
                cur_req = "R10";
                set_cfg((bot << 5) | (lvl << 2));
                for (int b = 0; b < 16; b++) begin
                    int a;
                    a = b * 65536 + 32'h123;
                    issue(0, 0, 1'b1, 0);
                    issue((b % 2 == 0) ? 4 : 5, a, 1'b1, 0);
                    chk(last_acc == !in_guarded(a, lvl, bot), "R10 block range", last_acc, !in_guarded(a, lvl, bot));
                    if (!last_acc) issue(1, 0, 1'b1, 0);
                    wait_idle();
                end
                cur_req = "R11";
                issue(0, 0, 1'b1, 0);
                issue(6, 0, 1'b1, 0);
                chk(last_acc == (lvl == 0), "R11 chip erase", last_acc, lvl == 0);
                if (!last_acc) issue(1, 0, 1'b1, 0);
                wait_idle();
            end
        end

        repeat (3) @(negedge clk);
        checking = 1'b0;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule